// File: doc/BRIEF.md
# Programmable Post-Scale Clock Divider

This block divides a fast source clock by a programmable integer and sets the duty cycle of the divided clock at half-source-period resolution. It receives eight copies of the source clock, spaced one eighth of a period apart. One of them is chosen as the counter clock, which gives a fine phase step of T/8. A programmable start delay of whole source cycles before the first output edge gives a coarse phase offset. The output stays high for a programmable high count and low for a programmable low count. A half-cycle adjust bit delays each rising edge by half a source period, so the duty cycle can be set in steps of 50%/N, where N is the high count plus the low count.

The sequencer is a four-state machine. ST_WAIT counts down the start delay. ST_HIGH and ST_LOW time the two output levels. ST_BYP covers a division of one, where the selected clock is passed through unchanged. The transitions are as follows:
- Reset enters ST_WAIT.
- ST_WAIT goes to ST_HIGH or ST_BYP when its count reaches zero.
- ST_HIGH goes to ST_LOW when its count reaches zero.
- ST_LOW goes to ST_HIGH or ST_BYP when its count reaches zero.
- ST_BYP re-evaluates the configuration on every cycle and either stays or goes to ST_HIGH.

The moves into ST_HIGH and ST_BYP are the period-start points. New settings are applied only at these points, so the output never glitches. For a feedback path, configure an exact 50% duty cycle: use an equal high and low count for an even N, or use the adjust bit for an odd N.

Top module: `prog_clk_div`

## Requirements
- R1: With the adjust bit clear and no bypass, the output is high for exactly `hi_cnt` selected-clock cycles and then low for exactly `lo_cnt` cycles, repeating with period `hi_cnt + lo_cnt`.
- R2: With the adjust bit set, each rising edge of the output comes half a source period after the counter edge. The output is then high for `hi_cnt - 0.5` cycles and low for `lo_cnt + 0.5` cycles. With N = 10 this reaches 5% (high 1, low 9, adjust set) and 90% (high 9, low 1, adjust clear).
- R3: All output edges are aligned to the selected phase input `k`, which lags phase input 0 by k/8 of a source period.
- R4: After reset is released, the output stays low for `start_dly` selected-clock cycles. It rises on rising edge number `start_dly + 1`.
- R5: When `hi_cnt + lo_cnt` equals 1 (one count is 1, the other is 0), the output equals the selected clock and the adjust bit is ignored.
- R6: A `load` sampled on a rising edge captures the count and adjust inputs. They take effect at the next period start strictly after that edge. A load on a period-start edge takes effect at the following period start.
- R7: Changes to the count and adjust inputs without `load` have no effect on the output while running.
- R8: While `rst` is high, the output is low. The counts, the adjust bit and the start delay are captured on the selected clock edges during reset.
- R9: `phase_sel` is sampled only while `rst` is high. A change to it while running has no effect on the phase of the output.
- R10: Outside bypass, a high or low count of zero acts as a count of one.
- R11: An odd division N gives exactly 50% duty when the high count is (N+1)/2, the low count is (N-1)/2 and the adjust bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ph_clk | input | 8 | Eight source clock phases; bit k lags bit 0 by k/8 period |
| rst | input | 1 | Synchronous reset; holds output low and captures settings |
| hi_cnt | input | 8 | High-time count in source cycles |
| lo_cnt | input | 8 | Low-time count in source cycles |
| start_dly | input | 8 | Start delay in source cycles after reset release |
| phase_sel | input | 3 | Index of the phase used as counter clock |
| half_adj | input | 1 | Delays each rising edge by half a source period |
| load | input | 1 | Capture strobe for counts and adjust bit |
| clk_out | output | 1 | Divided clock |

## Verification
The level change at each period boundary is driven by a register clocked on the selected rising edge, so it appears on the same edge that ends the count. The half-cycle delay appears at the next falling edge of the selected clock. A load sampled on edge L first affects the period that starts after L.

The bench model runs on the selected phase and builds a queue of expected levels, one entry per half source period. It compares the output one nanosecond after every rising and falling edge, so every sample falls inside a settled half-cycle. Phase alignment is checked separately: the time of an output rising edge, modulo the source period, must equal the offset of the selected phase.

// File: rtl/pdiv_pkg.sv
`timescale 1ps/1ps
package pdiv_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_BYP  = 2'd3
    } pdiv_state_e;
endpackage

// File: rtl/pdiv_phase_mux.sv
`timescale 1ps/1ps
module pdiv_phase_mux #(
    parameter int NPH = 8,
    localparam int SEL_W = $clog2(NPH)
) (
    input  logic [NPH-1:0]   ph_clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] phase_sel,
    output logic             ck_sel
);
    logic [SEL_W-1:0] sel_q;

    // selection register follows the input only during reset
    always_ff @(posedge ph_clk[0]) begin
        if (rst)
            sel_q <= phase_sel;
    end

    assign ck_sel = ph_clk[sel_q];

    // R9
    sel_hold_chk: assert property (@(posedge ph_clk[0]) disable iff (rst)
        !$past(rst) |-> $stable(sel_q));
endmodule

// File: rtl/pdiv_seq.sv
`timescale 1ps/1ps
module pdiv_seq
    import pdiv_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DLY_W = 8,
    localparam int CW = (CNT_W > DLY_W) ? CNT_W : DLY_W
) (
    input  logic             ck,
    input  logic             rst,
    input  logic [CNT_W-1:0] hi_in,
    input  logic [CNT_W-1:0] lo_in,
    input  logic             half_in,
    input  logic [DLY_W-1:0] dly_in,
    input  logic             load,
    output logic             out_pos,
    output logic             byp,
    output logic             half_act
);
    pdiv_state_e      state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             out_q, out_d;
    logic [CNT_W-1:0] hi_a, lo_a, hi_p, lo_p, hi_d, lo_d;
    logic             half_a, half_p, half_d, pend_v, take;
    logic [CNT_W-1:0] use_hi, use_lo;
    logic             use_half, use_byp;

    function automatic logic [CW-1:0] first_cnt(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : (CW'(v) - CW'(1));
    endfunction

    assign use_hi   = pend_v ? hi_p : hi_a;
    assign use_lo   = pend_v ? lo_p : lo_a;
    assign use_half = pend_v ? half_p : half_a;
    assign use_byp  = (({1'b0, use_hi} + {1'b0, use_lo}) == (CNT_W+1)'(1));

    // next-state and count logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        hi_d    = hi_a;
        lo_d    = lo_a;
        half_d  = half_a;
        take    = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (cnt_q == '0) take = 1'b1;
                else             cnt_d = cnt_q - CW'(1);
            end
            ST_HIGH: begin
                if (cnt_q == '0) begin
                    state_d = ST_LOW;
                    out_d   = 1'b0;
                    cnt_d   = first_cnt(lo_a);
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_LOW: begin
                if (cnt_q == '0) take = 1'b1;
                else             cnt_d = cnt_q - CW'(1);
            end
            ST_BYP: take = 1'b1;
        endcase
        if (take) begin
            hi_d   = use_hi;
            lo_d   = use_lo;
            half_d = use_half;
            if (use_byp) begin
                state_d = ST_BYP;
                out_d   = 1'b0;
            end else begin
                state_d = ST_HIGH;
                out_d   = 1'b1;
                cnt_d   = first_cnt(use_hi);
            end
        end
    end

    // state register
    always_ff @(posedge ck) begin
        if (rst) begin
            state_q <= ST_WAIT;
            cnt_q   <= CW'(dly_in);
            out_q   <= 1'b0;
            hi_a    <= hi_in;
            lo_a    <= lo_in;
            half_a  <= half_in;
            pend_v  <= 1'b0;
            hi_p    <= '0;
            lo_p    <= '0;
            half_p  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            out_q   <= out_d;
            hi_a    <= hi_d;
            lo_a    <= lo_d;
            half_a  <= half_d;
            if (take) pend_v <= 1'b0;
            if (load) begin
                hi_p   <= hi_in;
                lo_p   <= lo_in;
                half_p <= half_in;
                pend_v <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        out_pos  = out_q;
        byp      = (state_q == ST_BYP);
        half_act = half_a;
    end

    // R1
    hi_to_lo_chk: assert property (@(posedge ck) disable iff (rst)
        (state_q == ST_HIGH && cnt_q == '0) |=> (state_q == ST_LOW && !out_q));
    // R4
    wait_hold_chk: assert property (@(posedge ck) disable iff (rst)
        (state_q == ST_WAIT && cnt_q != '0) |=> (state_q == ST_WAIT && !out_q));
    // R6
    cfg_hold_chk: assert property (@(posedge ck) disable iff (rst)
        (state_q == ST_HIGH || (state_q == ST_LOW && cnt_q != '0))
        |=> ($stable(hi_a) && $stable(lo_a) && $stable(half_a)));
    // R5
    byp_cfg_chk: assert property (@(posedge ck) disable iff (rst)
        (state_q == ST_BYP) |-> (({1'b0, hi_a} + {1'b0, lo_a}) == (CNT_W+1)'(1)));
endmodule

// File: rtl/pdiv_edge_trim.sv
`timescale 1ps/1ps
module pdiv_edge_trim (
    input  logic ck,
    input  logic rst,
    input  logic out_pos,
    input  logic half_act,
    input  logic byp,
    output logic clk_out
);
    logic neg_q;

    // falling-edge copy of the level, used to delay the rise by half a cycle
    always_ff @(negedge ck) begin
        if (rst) neg_q <= 1'b0;
        else     neg_q <= out_pos;
    end

    always_comb begin
        if (rst)           clk_out = 1'b0;
        else if (byp)      clk_out = ck;
        else if (half_act) clk_out = out_pos & neg_q;
        else               clk_out = out_pos;
    end
endmodule

// File: rtl/prog_clk_div.sv
`timescale 1ps/1ps
module prog_clk_div #(
    parameter int NPH   = 8,
    parameter int CNT_W = 8,
    parameter int DLY_W = 8,
    localparam int SEL_W = $clog2(NPH)
) (
    input  logic [NPH-1:0]   ph_clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [DLY_W-1:0] start_dly,
    input  logic [SEL_W-1:0] phase_sel,
    input  logic             half_adj,
    input  logic             load,
    output logic             clk_out
);
    logic ck_sel, out_pos, byp, half_act;

    pdiv_phase_mux #(.NPH(NPH)) u_mux (
        .ph_clk(ph_clk), .rst(rst), .phase_sel(phase_sel), .ck_sel(ck_sel)
    );

    pdiv_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_seq (
        .ck(ck_sel), .rst(rst), .hi_in(hi_cnt), .lo_in(lo_cnt),
        .half_in(half_adj), .dly_in(start_dly), .load(load),
        .out_pos(out_pos), .byp(byp), .half_act(half_act)
    );

    pdiv_edge_trim u_trim (
        .ck(ck_sel), .rst(rst), .out_pos(out_pos), .half_act(half_act),
        .byp(byp), .clk_out(clk_out)
    );
endmodule

// File: tb/test_prog_clk_div.sv
`timescale 1ps/1ps
module test_prog_clk_div;
    logic [7:0] ph;
    for (genvar k = 0; k < 8; k++) begin : g_ph
        bit c = 1'b0;
        initial begin
            #(k*500);
            forever #2000 c = ~c;
        end
        assign ph[k] = c;
    end

    logic       rst = 1'b1;
    logic [7:0] hi_cnt = 8'd3, lo_cnt = 8'd2, start_dly = 8'd0;
    logic [2:0] phase_sel = 3'd0;
    logic       half_adj = 1'b0, load = 1'b0;
    logic       clk_out;

    prog_clk_div i_prog_clk_div (
        .ph_clk(ph), .rst(rst), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
        .start_dly(start_dly), .phase_sel(phase_sel), .half_adj(half_adj),
        .load(load), .clk_out(clk_out)
    );

    int    sel_m = 0;
    logic  ck_m;
    assign ck_m = ph[sel_m];

    int    checks = 0, errs = 0;
    bit    chk_en = 1'b0;
    string req = "R8";
    bit    q[$];
    int    m_hi, m_lo, p_hi, p_lo;
    bit    m_half, p_half, p_v;

    task automatic cmp(input bit e, input string r);
        checks++;
        if (clk_out !== e) begin
            errs++;
            $display("FAIL %s: clk_out=%0b expected %0b at %0t", r, clk_out, e, $time);
        end
    endtask

    function automatic void push_period();
        if (m_hi + m_lo == 1) begin
            q.push_back(1'b1);
            q.push_back(1'b0);
        end else begin
            int h = (m_hi == 0) ? 1 : m_hi;
            int l = (m_lo == 0) ? 1 : m_lo;
            for (int i = 0; i < 2*h; i++) q.push_back(!(m_half && i == 0));
            for (int i = 0; i < 2*l; i++) q.push_back(1'b0);
        end
    endfunction

    // reference model: one expected level per half source period
    always @(posedge ck_m) begin
        bit e;
        if (rst) begin
            q.delete();
            for (int i = 0; i < 2*int'(start_dly); i++) q.push_back(1'b0);
            m_hi = hi_cnt; m_lo = lo_cnt; m_half = half_adj; p_v = 0;
            #1000;
            if (chk_en) cmp(1'b0, "R8");
        end else begin
            if (q.size() == 0) begin
                if (p_v) begin
                    m_hi = p_hi; m_lo = p_lo; m_half = p_half; p_v = 0;
                end
                push_period();
            end
            if (load) begin
                p_hi = lo_cnt == lo_cnt ? int'(hi_cnt) : 0;
                p_lo = lo_cnt; p_half = half_adj; p_v = 1;
            end
            e = q.pop_front();
            #1000;
            if (chk_en && !rst) cmp(e, req);
        end
    end

    always @(negedge ck_m) begin
        bit e2;
        if (!rst && q.size() > 0) begin
            e2 = q.pop_front();
            #1000;
            if (chk_en && !rst) cmp(e2, req);
        end
    end

    task automatic do_reset(input int sel, input int h, input int l, input bit hf, input int d);
        rst = 1'b1;
        hi_cnt = 8'(h); lo_cnt = 8'(l); half_adj = hf; start_dly = 8'(d);
        phase_sel = 3'(sel); sel_m = sel;
        repeat (4) @(posedge ph[0]);
        @(negedge ck_m);
        #300 rst = 1'b0;
    endtask

    task automatic do_load(input int h, input int l, input bit hf);
        @(posedge ck_m);
        #300;
        hi_cnt = 8'(h); lo_cnt = 8'(l); half_adj = hf; load = 1'b1;
        @(posedge ck_m);
        #300 load = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge ck_m);
        #1500;
    endtask

    task automatic check_phase(input int k, input string r);
        longint expv = (2000 + 500*k) % 4000;
        @(posedge clk_out);
        checks++;
        if (($time % 4000) != expv) begin
            errs++;
            $display("FAIL %s: rise offset=%0d expected %0d", r, $time % 4000, expv);
        end
    endtask

    initial begin : watchdog
        #60_000_000;
        errs++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #100;
        cmp(1'b0, "R8");
        chk_en = 1'b1;
        req = "R1";  do_reset(0, 3, 2, 0, 0); run(40);
        req = "R4";  do_reset(0, 2, 2, 0, 5); run(30);
        req = "R2";  do_load(1, 9, 1); run(45);
        do_load(9, 1, 0); run(45);
        req = "R11"; do_load(3, 2, 1); run(30);
        req = "R5";  do_load(1, 0, 1); run(20);
        req = "R6";  do_load(2, 3, 0); run(30);
        do_load(4, 1, 0); do_load(2, 2, 1); run(30);
        req = "R7";  hi_cnt = 8'd7; lo_cnt = 8'd6; half_adj = 1'b1; run(30);
        req = "R10"; do_load(0, 3, 0); run(30);
        req = "R3";  do_reset(5, 2, 2, 0, 0); run(10);
        check_phase(5, "R3");
        req = "R9";  phase_sel = 3'd2; run(30);
        check_phase(5, "R9");
        run(5);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule